// File: doc/BRIEF.md
# Charge Controller Poll Request Generator

This block plays the role of a display panel talking to a solar charge controller over a serial link. It decides which request frame goes out next and produces that frame one byte at a time for a UART transmitter. It uses a valid/ready byte handshake and stalls whenever the transmitter is busy. Each frame has a six-byte sync run, a direction byte, a command, a length, a payload of up to seven bytes, a CRC-16 and a closing marker.

Once reset is released, the block sends a single settings-read request. It never repeats that request on its own. From then on a cycle-count timer issues real-time data polls at a programmable interval, and an interval of zero halts polling. A host can pulse in a load on/off command or a seven-byte settings write at any moment. A pending command waits until the frame currently on the wire has finished, and then goes ahead of any waiting poll. After a settings write, the block sends nothing until the receiver reports a confirmation or a programmable timeout expires. On a timeout it raises an error flag.

Top module: `chg_poll_gen`

## Requirements
- R1: The first frame after reset is a settings read: command 0xAC, length 0x01, payload 0x00. During reset `tx_valid`, `ack_wait` and `ack_err` are low. The settings read is never sent again without a new reset.
- R2: Every frame is the byte sequence EB 90 EB 90 EB 90, direction 0x01, command, length, the payload bytes, CRC high byte, CRC low byte, 0x7F.
- R3: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. Bits are processed MSB first, with no reflection and no final XOR. It covers the direction byte through the last payload byte.
- R4: A poll frame carries command 0xA0, length 0x01 and payload 0x03. With a nonzero `poll_interval` of N cycles and a free link, successive poll frames start exactly N cycles apart.
- R5: With `poll_interval` at zero no new poll becomes due. A poll that was already due is still sent.
- R6: A `load_req` pulse captures `load_on` and sends command 0xAA, length 0x01, with payload 0x01 for on and 0x00 for off.
- R7: A `wr_req` pulse captures `wr_data` and sends command 0xAD, length 0x07. The payload is `wr_data[55:48]` first and `wr_data[7:0]` last.
- R8: A frame on the wire is never interrupted. When the link becomes free, the next frame is chosen in this order: pending load, then pending write, then due poll.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_data` holds its value. A byte is consumed only in a cycle where both signals are high.
- R10: After the last byte of a settings write is consumed, `ack_wait` is high and no frame starts until the wait ends.
- R11: An `rx_ack` pulse during the wait ends the wait on the next edge and clears `ack_err`. An `rx_ack` pulse outside the wait has no effect.
- R12: If no confirmation arrives, the wait ends `ack_timeout`+1 cycles after the last byte and `ack_err` is set. Polling then resumes, and `ack_err` clears when the next settings write frame starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_interval | input | POLL_W | Poll period in clock cycles; zero stops polling |
| ack_timeout | input | TMO_W | Cycles to wait for a write confirmation |
| load_req | input | 1 | One-cycle request for a load command |
| load_on | input | 1 | Load state captured with `load_req` |
| wr_req | input | 1 | One-cycle request for a settings write |
| wr_data | input | 56 | Seven settings bytes, most significant sent first |
| rx_ack | input | 1 | Receiver strobe: write confirmation seen |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | A frame byte is offered |
| tx_data | output | 8 | Offered frame byte |
| ack_wait | output | 1 | Waiting for a write confirmation |
| ack_err | output | 1 | Last settings write was not confirmed |

## Verification
A byte-level scoreboard rebuilds every expected frame from its command and payload, including its own bitwise CRC. Each frame the block sends is compared in full against that rebuilt frame. This catches errors in framing, payload order or CRC, whether the transmitter accepts every byte, every other byte, or is held off for many cycles. Long idle windows with a zero interval show that the startup request is sent only once and that no poll appears. Measuring start-to-start spacing with a free link checks the interval counter itself. Loads, writes and polls are piled up behind a stalled frame to show the selection order. A write answered by a confirmation is compared with one left to time out, which separates the two ways a wait can end and shows the exact cycle at which the error flag appears.

// File: rtl/chg_poll_pkg.sv
package chg_poll_pkg;

   localparam logic [7:0] SYNC_A    = 8'hEB;
   localparam logic [7:0] SYNC_B    = 8'h90;
   localparam logic [7:0] DIR_REQ   = 8'h01;
   localparam logic [7:0] END_MARK  = 8'h7F;

   localparam logic [7:0] CMD_SETRD = 8'hAC;
   localparam logic [7:0] CMD_POLL  = 8'hA0;
   localparam logic [7:0] CMD_LOAD  = 8'hAA;
   localparam logic [7:0] CMD_SETWR = 8'hAD;
   localparam logic [7:0] POLL_ARG  = 8'h03;

   localparam int WR_BYTES  = 7;
   localparam int PAY_W     = 8 * WR_BYTES;
   localparam int SYNC_LEN  = 6;
   localparam int IDX_W     = 5;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_SEND,
      ST_WAIT
   } link_st_t;

   typedef struct packed {
      logic [7:0]       cmd;
      logic [2:0]       len;
      logic [PAY_W-1:0] pay;
   } frame_desc_t;

endpackage

// File: rtl/cpg_crc16_step.sv
module cpg_crc16_step #(
   parameter logic [15:0] POLY      = 16'h1021,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic [15:0] crc_in,
   input  logic [7:0]  din,
   output logic [15:0] crc_out
);

   generate
      if (MSB_FIRST) begin : g_msb
         always_comb begin
            logic [15:0] c;
            c = crc_in ^ {din, 8'h00};
            for (int b = 0; b < 8; b++) begin
               c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
            end
            crc_out = c;
         end
      end else begin : g_lsb
         always_comb begin
            logic [15:0] c;
            c = crc_in ^ {8'h00, din};
            for (int b = 0; b < 8; b++) begin
               c = c[0] ? ((c >> 1) ^ POLY) : (c >> 1);
            end
            crc_out = c;
         end
      end
   endgenerate

endmodule

// File: rtl/cpg_interval_timer.sv
module cpg_interval_timer #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] interval,
   input  logic         take,
   output logic         due
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
         due <= 1'b0;
      end else begin
         if (take) due <= 1'b0;
         if (interval == '0) begin
            cnt <= '0;
         end else if (cnt >= interval - 1'b1) begin
            cnt <= '0;
            due <= 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cpg_frame_seq.sv
module cpg_frame_seq
   import chg_poll_pkg::*;
#(
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_INIT      = 16'hFFFF,
   parameter bit          CRC_MSB_FIRST = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  frame_desc_t desc,
   input  logic        tx_ready,
   output logic        tx_valid,
   output logic [7:0]  tx_data,
   output logic        done
);

   logic             active;
   logic [IDX_W-1:0] idx;
   logic [15:0]      crc_q;
   logic [15:0]      crc_nx;
   logic [7:0]       cmd_q;
   logic [2:0]       len_q;
   logic [PAY_W-1:0] pay_sh;
   logic [7:0]       cur;
   logic             fire;

   logic [IDX_W-1:0] len_x;
   logic [IDX_W-1:0] data_end;
   logic [IDX_W-1:0] crc_hi_idx;
   logic [IDX_W-1:0] last_idx;
   logic             in_crc;
   logic             in_pay;

   assign len_x      = {{(IDX_W-3){1'b0}}, len_q};
   assign data_end   = IDX_W'(8) + len_x;
   assign crc_hi_idx = IDX_W'(9) + len_x;
   assign last_idx   = IDX_W'(11) + len_x;
   assign in_crc     = (idx >= IDX_W'(6)) && (idx <= data_end);
   assign in_pay     = (idx >= IDX_W'(9)) && (idx <= data_end);
   assign fire       = active && tx_ready;

   always_comb begin
      if (idx < IDX_W'(SYNC_LEN))          cur = idx[0] ? SYNC_B : SYNC_A;
      else if (idx == IDX_W'(6))           cur = DIR_REQ;
      else if (idx == IDX_W'(7))           cur = cmd_q;
      else if (idx == IDX_W'(8))           cur = {5'b0, len_q};
      else if (idx <= data_end)            cur = pay_sh[PAY_W-1 -: 8];
      else if (idx == crc_hi_idx)          cur = crc_q[15:8];
      else if (idx == crc_hi_idx + 1'b1)   cur = crc_q[7:0];
      else                                 cur = END_MARK;
   end

   cpg_crc16_step #(
      .POLY      (CRC_POLY),
      .MSB_FIRST (CRC_MSB_FIRST)
   ) u_crc (
      .crc_in  (crc_q),
      .din     (cur),
      .crc_out (crc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         crc_q  <= CRC_INIT;
         cmd_q  <= '0;
         len_q  <= '0;
         pay_sh <= '0;
      end else if (!active) begin
         if (start) begin
            active <= 1'b1;
            idx    <= '0;
            crc_q  <= CRC_INIT;
            cmd_q  <= desc.cmd;
            len_q  <= desc.len;
            pay_sh <= desc.pay;
         end
      end else if (fire) begin
         if (in_crc) crc_q <= crc_nx;
         if (in_pay) pay_sh <= {pay_sh[PAY_W-9:0], 8'h00};
         if (idx == last_idx) active <= 1'b0;
         else                 idx    <= idx + 1'b1;
      end
   end

   assign tx_valid = active;
   assign tx_data  = cur;
   assign done     = fire && (idx == last_idx);

endmodule

// File: rtl/chg_poll_gen.sv
module chg_poll_gen
   import chg_poll_pkg::*;
#(
   parameter int          POLL_W        = 24,
   parameter int          TMO_W         = 16,
   parameter logic [15:0] CRC_POLY      = 16'h1021,
   parameter logic [15:0] CRC_INIT      = 16'hFFFF,
   parameter bit          CRC_MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [POLL_W-1:0] poll_interval,
   input  logic [TMO_W-1:0]  ack_timeout,
   input  logic              load_req,
   input  logic              load_on,
   input  logic              wr_req,
   input  logic [55:0]       wr_data,
   input  logic              rx_ack,
   input  logic              tx_ready,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              ack_wait,
   output logic              ack_err
);

   localparam int PAD_W = PAY_W - 8;

   generate
      if (POLL_W < 2 || POLL_W > 32) begin : g_bad_poll_w
         $error("POLL_W must lie in 2..32");
      end
      if (TMO_W < 1 || TMO_W > 32) begin : g_bad_tmo_w
         $error("TMO_W must lie in 1..32");
      end
      if (PAY_W != 56) begin : g_bad_pay
         $error("settings payload must be seven bytes");
      end
   endgenerate

   link_st_t         st;
   logic             boot_pend;
   logic             load_pend;
   logic             load_val;
   logic             wr_pend;
   logic [PAY_W-1:0] wr_q;
   logic             cur_wr;
   logic [TMO_W-1:0] wait_cnt;
   logic             poll_due;

   logic             pick_boot, pick_load, pick_wr, pick_poll;
   logic             start;
   logic             take_boot, take_load, take_wr, take_poll;
   frame_desc_t      sel_desc;
   logic             frame_done;

   // selection order: startup read, load, settings write, poll
   always_comb begin
      pick_boot = boot_pend;
      pick_load = !boot_pend && load_pend;
      pick_wr   = !boot_pend && !load_pend && wr_pend;
      pick_poll = !boot_pend && !load_pend && !wr_pend && poll_due;
      start     = (st == ST_IDLE) && (boot_pend || load_pend || wr_pend || poll_due);
      take_boot = start && pick_boot;
      take_load = start && pick_load;
      take_wr   = start && pick_wr;
      take_poll = start && pick_poll;

      sel_desc.cmd = CMD_POLL;
      sel_desc.len = 3'd1;
      sel_desc.pay = {POLL_ARG, {PAD_W{1'b0}}};
      if (pick_boot) begin
         sel_desc.cmd = CMD_SETRD;
         sel_desc.pay = {8'h00, {PAD_W{1'b0}}};
      end else if (pick_load) begin
         sel_desc.cmd = CMD_LOAD;
         sel_desc.pay = {7'b0, load_val, {PAD_W{1'b0}}};
      end else if (pick_wr) begin
         sel_desc.cmd = CMD_SETWR;
         sel_desc.len = 3'(WR_BYTES);
         sel_desc.pay = wr_q;
      end
   end

   cpg_interval_timer #(
      .W (POLL_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .interval (poll_interval),
      .take     (take_poll),
      .due      (poll_due)
   );

   cpg_frame_seq #(
      .CRC_POLY      (CRC_POLY),
      .CRC_INIT      (CRC_INIT),
      .CRC_MSB_FIRST (CRC_MSB_FIRST)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .desc     (sel_desc),
      .tx_ready (tx_ready),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .done     (frame_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         boot_pend <= 1'b1;
         load_pend <= 1'b0;
         load_val  <= 1'b0;
         wr_pend   <= 1'b0;
         wr_q      <= '0;
         cur_wr    <= 1'b0;
         wait_cnt  <= '0;
         ack_err   <= 1'b0;
      end else begin
         if (take_boot) boot_pend <= 1'b0;

         if (load_req) begin
            load_pend <= 1'b1;
            load_val  <= load_on;
         end else if (take_load) begin
            load_pend <= 1'b0;
         end

         if (wr_req) begin
            wr_pend <= 1'b1;
            wr_q    <= wr_data;
         end else if (take_wr) begin
            wr_pend <= 1'b0;
         end

         case (st)
            ST_IDLE: begin
               if (start) begin
                  st     <= ST_SEND;
                  cur_wr <= take_wr;
                  if (take_wr) ack_err <= 1'b0;
               end
            end
            ST_SEND: begin
               if (frame_done) begin
                  wait_cnt <= '0;
                  st       <= cur_wr ? ST_WAIT : ST_IDLE;
               end
            end
            ST_WAIT: begin
               if (rx_ack) begin
                  st      <= ST_IDLE;
                  ack_err <= 1'b0;
               end else if (wait_cnt == ack_timeout) begin
                  st      <= ST_IDLE;
                  ack_err <= 1'b1;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign ack_wait = (st == ST_WAIT);

endmodule

// File: rtl/chg_poll_gen_chk.sv
module chg_poll_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic [7:0] tx_data,
   input logic       ack_wait,
   input logic       ack_err,
   input logic       rx_ack
);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)))
      else $error("R9 byte changed while stalled");

   p_sync_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_valid) |-> (tx_data == 8'hEB))
      else $error("R2 frame did not open with sync byte");

   p_quiet_wait_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wait |-> !tx_valid)
      else $error("R10 byte offered during confirmation wait");

   p_ack_ends_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wait && rx_ack) |=> (!ack_wait && !ack_err))
      else $error("R11 confirmation did not end the wait");

   p_err_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_err) |-> $past(ack_wait))
      else $error("R12 error raised outside a wait");

endmodule

bind chg_poll_gen chg_poll_gen_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .tx_data  (tx_data),
   .ack_wait (ack_wait),
   .ack_err  (ack_err),
   .rx_ack   (rx_ack)
);

// File: tb/chg_poll_gen_tb_top.sv
`timescale 1ns/1ps
module chg_poll_gen_tb_top;

   localparam int POLL_W = 24;
   localparam int TMO_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [POLL_W-1:0] poll_interval = '0;
   logic [TMO_W-1:0]  ack_timeout = 16'd60;
   logic              load_req = 1'b0;
   logic              load_on = 1'b0;
   logic              wr_req = 1'b0;
   logic [55:0]       wr_data = '0;
   logic              rx_ack = 1'b0;
   logic              tx_ready = 1'b1;
   logic              tx_valid;
   logic [7:0]        tx_data;
   logic              ack_wait;
   logic              ack_err;

   always #2 clk = ~clk;

   chg_poll_gen #(.POLL_W(POLL_W), .TMO_W(TMO_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .poll_interval(poll_interval), .ack_timeout(ack_timeout),
      .load_req(load_req), .load_on(load_on), .wr_req(wr_req), .wr_data(wr_data),
      .rx_ack(rx_ack), .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
      .ack_wait(ack_wait), .ack_err(ack_err)
   );

   typedef struct {
      logic [7:0]  cmd;
      int          len;
      logic [55:0] pay;
      string       req;
   } exp_t;

   exp_t       exp_q[$];
   int         total = 0;
   int         bad = 0;
   int         cyc = 0;
   int         ready_mode = 1;
   int         n_frames = 0;
   int         n_starts = 0;
   int         last_end_cyc = 0;
   int         start_cyc[0:63];
   logic [7:0] cur_b[0:18];
   int         cur_n = 0;
   logic [7:0] exp_b[0:18];
   int         exp_n = 0;
   bit         finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] ref_crc(input int first, input int last);
      logic [15:0] c = 16'hFFFF;
      for (int i = first; i <= last; i++) begin
         c ^= {exp_b[i], 8'h00};
         for (int k = 0; k < 8; k++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
      end
      return c;
   endfunction

   function automatic void build_exp(input exp_t e);
      logic [15:0] c;
      for (int i = 0; i < 6; i++) exp_b[i] = (i % 2 == 0) ? 8'hEB : 8'h90;
      exp_b[6] = 8'h01;
      exp_b[7] = e.cmd;
      exp_b[8] = 8'(e.len);
      for (int k = 0; k < e.len; k++) exp_b[9+k] = e.pay[55-8*k -: 8];
      c = ref_crc(6, 8 + e.len);
      exp_b[9+e.len]  = c[15:8];
      exp_b[10+e.len] = c[7:0];
      exp_b[11+e.len] = 8'h7F;
      exp_n = 12 + e.len;
   endfunction

   task automatic push(input logic [7:0] cmd, input int len, input logic [55:0] pay, input string req);
      exp_t e;
      e.cmd = cmd; e.len = len; e.pay = pay; e.req = req;
      exp_q.push_back(e);
   endtask

   // monitor: assembles frames and compares them with the scoreboard head
   always @(negedge clk) begin
      if (rst_n && tx_valid && tx_ready) begin
         int flen;
         if (cur_n == 0) begin
            if (n_starts < 64) start_cyc[n_starts] = cyc;
            n_starts++;
         end
         cur_b[cur_n] = tx_data;
         cur_n++;
         flen = 19;
         if (cur_n >= 9) flen = 12 + ((cur_b[8] > 8'd7) ? 7 : int'(cur_b[8]));
         if (cur_n >= flen) begin
            exp_t e;
            int   bad_i;
            n_frames++;
            last_end_cyc = cyc;
            cur_n = 0;
            if (exp_q.size() == 0) begin
               chk(0, "R1", "unexpected frame cmd", int'(cur_b[7]), 0);
            end else begin
               e = exp_q.pop_front();
               build_exp(e);
               bad_i = -1;
               if (flen != exp_n) bad_i = 8;
               else for (int i = 0; i < flen; i++) if (bad_i < 0 && cur_b[i] !== exp_b[i]) bad_i = i;
               if (bad_i < 0) chk(1, e.req, "frame", 0, 0);
               else chk(0, e.req, $sformatf("frame byte %0d", bad_i), int'(cur_b[bad_i]), int'(exp_b[bad_i]));
            end
         end
      end
   end

   initial begin
      forever begin
         @(posedge clk);
         #1;
         case (ready_mode)
            0: tx_ready = 1'b1;
            1: tx_ready = ~tx_ready;
            default: tx_ready = 1'b0;
         endcase
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wait_frames(input int n);
      while (n_frames < n) @(negedge clk);
   endtask

   task automatic wait_starts(input int n);
      while (n_starts < n) @(negedge clk);
   endtask

   task automatic pulse_load(input logic v);
      @(negedge clk); load_on = v; load_req = 1'b1;
      @(negedge clk); load_req = 1'b0;
   endtask

   task automatic pulse_wr(input logic [55:0] d);
      @(negedge clk); wr_data = d; wr_req = 1'b1;
      @(negedge clk); wr_req = 1'b0;
   endtask

   task automatic pulse_ack();
      @(negedge clk); rx_ack = 1'b1;
      @(negedge clk); rx_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R1", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int c0;
      // reset state (R1)
      wait_cyc(4);
      chk(tx_valid == 1'b0, "R1", "tx_valid in reset", int'(tx_valid), 0);
      chk(ack_wait == 1'b0 && ack_err == 1'b0, "R1", "flags in reset", int'({ack_wait, ack_err}), 0);
      push(8'hAC, 1, 56'h0, "R1 R2 R3 R9 startup read");
      rst_n = 1'b1;
      wait_frames(1);
      wait_cyc(300);
      chk(n_frames == 1, "R1", "startup read repeated or poll with zero interval (R5)", n_frames, 1);

      // periodic polls, free link (R4)
      ready_mode = 0;
      for (int i = 0; i < 3; i++) push(8'hA0, 1, {8'h03, 48'h0}, "R4 poll");
      poll_interval = 24'd100;
      wait_starts(4);
      poll_interval = '0;
      wait_frames(4);
      chk(start_cyc[2] - start_cyc[1] == 100, "R4", "poll spacing 1", start_cyc[2] - start_cyc[1], 100);
      chk(start_cyc[3] - start_cyc[2] == 100, "R4", "poll spacing 2", start_cyc[3] - start_cyc[2], 100);
      wait_cyc(300);
      chk(n_frames == 4, "R5", "frames after interval cleared", n_frames, 4);

      // load commands (R6)
      push(8'hAA, 1, {8'h01, 48'h0}, "R6 load on");
      pulse_load(1'b1);
      wait_frames(5);
      push(8'hAA, 1, {8'h00, 48'h0}, "R6 load off");
      pulse_load(1'b0);
      wait_frames(6);

      // settings write with confirmation (R7 R10 R11)
      push(8'hAD, 7, 56'h00000A03141012, "R7 settings write");
      pulse_wr(56'h00000A03141012);
      wait_frames(7);
      wait_cyc(5);
      chk(ack_wait == 1'b1, "R10", "waiting after write", int'(ack_wait), 1);
      pulse_ack();
      @(negedge clk);
      chk(ack_wait == 1'b0 && ack_err == 1'b0, "R11", "ack ends wait", int'({ack_wait, ack_err}), 0);

      // colliding requests behind a stalled frame (R8 R9 R5)
      ack_timeout = 16'd1000;
      ready_mode = 2;
      poll_interval = 24'd5;
      wait_cyc(20);
      pulse_load(1'b1);
      pulse_wr(56'h11223344556677);
      poll_interval = '0;
      push(8'hA0, 1, {8'h03, 48'h0}, "R9 stalled poll");
      push(8'hAA, 1, {8'h01, 48'h0}, "R8 load first");
      push(8'hAD, 7, 56'h11223344556677, "R8 write second");
      ready_mode = 1;
      wait_frames(10);
      wait_cyc(5);
      chk(ack_wait == 1'b1 && n_frames == 10, "R10", "due poll held during wait", n_frames, 10);
      push(8'hA0, 1, {8'h03, 48'h0}, "R5 due poll after wait");
      pulse_ack();
      wait_frames(11);
      ready_mode = 0;
      wait_cyc(200);
      chk(n_frames == 11, "R5", "no further polls", n_frames, 11);

      // unconfirmed write (R12)
      ack_timeout = 16'd60;
      push(8'hAD, 7, 56'hA5A5A5A5A5A5A5, "R7 write to time out");
      pulse_wr(56'hA5A5A5A5A5A5A5);
      wait_frames(12);
      c0 = last_end_cyc;
      poll_interval = 24'd40;
      push(8'hA0, 1, {8'h03, 48'h0}, "R12 polling resumes");
      while (cyc < c0 + 61) @(negedge clk);
      chk(ack_wait == 1'b1 && ack_err == 1'b0, "R12", "still waiting at timeout", int'({ack_wait, ack_err}), 2);
      @(negedge clk);
      chk(ack_wait == 1'b0 && ack_err == 1'b1, "R12", "timeout raises error", int'({ack_wait, ack_err}), 1);
      wait_starts(13);
      poll_interval = '0;
      chk(start_cyc[12] > c0 + 61, "R10", "poll start after wait", start_cyc[12], c0 + 62);
      wait_frames(13);

      // ack outside wait ignored (R11)
      pulse_ack();
      wait_cyc(3);
      chk(ack_err == 1'b1 && ack_wait == 1'b0, "R11", "stray ack ignored", int'({ack_wait, ack_err}), 1);

      // error clears when next write starts (R12)
      push(8'hAD, 7, 56'h01020304050607, "R7 R12 next write");
      pulse_wr(56'h01020304050607);
      wait_starts(14);
      @(negedge clk);
      chk(ack_err == 1'b0, "R12", "error cleared at write start", int'(ack_err), 0);
      wait_frames(14);
      pulse_ack();
      wait_cyc(50);
      chk(exp_q.size() == 0, "R2", "expected frames left", exp_q.size(), 0);
      finish_run();
   end

endmodule